// File: doc/BRIEF.md
# Processor Tick Timer with Period Compare

The block is a tick timer for a CPU core. It holds a 32-bit count and a control word. The control word has a period compare field, an interrupt enable, a sticky interrupt-pending flag and a two-bit operating mode. Each cycle with the `tick` strobe high stands for one count interval, which is 50 ns at the intended 20 MHz tick rate. The strobe advances the count by one whenever the mode allows counting.

A compare event occurs when the low period-width bits of the advanced count equal the period field. Count bits above that width take no part in the compare. The mode then decides what happens next: the count restarts from zero, it freezes, or it keeps running through the full 32-bit range. If the interrupt enable is set, the event also latches the pending flag, and the level interrupt to the core follows it.

Software reaches both registers through a single-cycle write port and a combinational read port.

Top module: `tick_timer`

## Requirements
- R1: After reset the count and the whole control word read as zero, and `irq` is low.
- R2: With `rd_sel`=0, `rd_data` returns the count. With `rd_sel`=1 it returns the control word: period in bits 27:0, pending in bit 28, enable in bit 29, mode in bits 31:30. A write with `wr_sel`=0 targets the count, and a write with `wr_sel`=1 targets the control word.
- R3: On a cycle with `tick` high and no write, the count increments by one in mode 1, in mode 3, and in mode 2 until its compare event. In mode 0 the count does not change.
- R4: A compare event occurs when bits 27:0 of the incremented count equal the period field, whatever bits 31:28 hold. If the count's low bits are already at or past the period, the event comes only after those bits wrap through zero.
- R5: In mode 1 a compare event loads zero into the count instead of the incremented value.
- R6: In mode 2 the count takes the matching value and then holds on later ticks, until the control word is written.
- R7: In mode 3 a compare event leaves the count incrementing, and the count wraps from 0xFFFFFFFF to 0.
- R8: A compare event sets the pending bit if the enable bit is 1. It leaves the pending bit alone if the enable bit is 0.
- R9: The pending bit is sticky. Only a control-word write with bit 28 at 0 clears it. `irq` is high exactly when pending and enable are both 1.
- R10: A register write takes the place of that cycle's tick action: a count write loads `wr_data` with no increment and no compare event that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one pulse per count interval |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 control word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 count, 1 control word |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level timer interrupt to the core |

## Verification
A wrong one-shot stop flag or a wrong mode decode shows up on the next tick, as a count that moves when it should hold or holds when it should move. A compare that wrongly uses the upper count bits, or that is off by one, shows on the tick of the expected event. There the count fails to drop to zero, or the pending bit and `irq` fail to rise. Both registers and `irq` are compared with a behavioural model after every clock, so a single wrong cycle is reported in that same cycle.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int PER_W = DATA_W - 4;
  localparam logic [1:0] M_OFF = 2'd0, M_RESTART = 2'd1, M_ONCE = 2'd2, M_CONT = 2'd3;

  logic [DATA_W-1:0] cnt_q;
  logic [PER_W-1:0]  per_q;
  logic              pend_q, ie_q, stop_q;
  logic [1:0]        mode_q;

  wire [DATA_W-1:0] cnt_inc = cnt_q + 1'b1;
  wire running = (mode_q == M_RESTART) || (mode_q == M_CONT) || (mode_q == M_ONCE && !stop_q);
  wire step    = tick && running && !wr_en;
  wire hit     = step && (cnt_inc[PER_W-1:0] == per_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= M_OFF;
      stop_q <= 1'b0;
    end else if (wr_en && !wr_sel) begin
      cnt_q <= wr_data;
    end else if (wr_en) begin
      per_q  <= wr_data[PER_W-1:0];
      pend_q <= wr_data[PER_W];
      ie_q   <= wr_data[PER_W+1];
      mode_q <= wr_data[DATA_W-1 -: 2];
      stop_q <= 1'b0;
    end else if (step) begin
      cnt_q <= (hit && mode_q == M_RESTART) ? '0 : cnt_inc;
      if (hit && mode_q == M_ONCE) stop_q <= 1'b1;
      if (hit && ie_q) pend_q <= 1'b1;
    end
  end

  assign rd_data = rd_sel ? {mode_q, ie_q, pend_q, per_q} : cnt_q;
  assign irq     = pend_q && ie_q;
endmodule

module tick_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-5:0] per_q,
  input logic              pend_q,
  input logic [1:0]        mode_q,
  input logic              irq
);
  logic [DATA_W-1:0] nxt;
  assign nxt = cnt_q + 1'b1;

  // R3
  hold_in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode_q == 2'd0) |=> $stable(cnt_q));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick && mode_q == 2'd1 && nxt[DATA_W-5:0] == per_q) |=> (cnt_q == '0));

  // R7
  cont_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick && mode_q == 2'd3) |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));

  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && pend_q) |=> (pend_q && (irq || !$past(irq))));

  // R10
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (cnt_q == $past(wr_data)));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .cnt_q(cnt_q), .per_q(per_q), .pend_q(pend_q),
  .mode_q(mode_q), .irq(irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  longint unsigned m_cnt;
  int unsigned m_per, m_mode;
  bit m_pend, m_ie, m_stop;

  function automatic logic [31:0] m_word();
    return {m_mode[1:0], m_ie, m_pend, m_per[27:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    rd_sel = 1'b0; #1;
    chk("R3 count", rd_data, m_cnt[31:0]);
    rd_sel = 1'b1; #1;
    chk("R2 control", rd_data, m_word());
    chk("R9 irq", {31'd0, irq}, {31'd0, m_pend & m_ie});
  endtask

  task automatic cyc(input bit w, input bit sel, input logic [31:0] d, input bit tk);
    longint unsigned nxt;
    bit run;
    wr_en = w; wr_sel = sel; wr_data = d; tick = tk;
    @(posedge clk);
    if (w && !sel) m_cnt = d;
    else if (w) begin
      m_per = d & 32'h0FFF_FFFF; m_pend = d[28]; m_ie = d[29]; m_mode = d >> 30; m_stop = 0;
    end else begin
      run = (m_mode == 1) || (m_mode == 3) || (m_mode == 2 && !m_stop);
      if (tk && run) begin
        nxt = (m_cnt + 1) % 64'h1_0000_0000;
        if ((nxt % 64'h1000_0000) == m_per) begin
          if (m_ie) m_pend = 1;
          if (m_mode == 1) nxt = 0;
          if (m_mode == 2) m_stop = 1;
        end
        m_cnt = nxt;
      end
    end
    #2;
    compare_all();
    wr_en = 1'b0; tick = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int md, input bit ie, input bit pd, input int per);
    return {md[1:0], ie, pd, per[27:0]};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_per = 0; m_mode = 0; m_pend = 0; m_ie = 0; m_stop = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    compare_all();
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R3: mode 0 ignores ticks
    repeat (4) cyc(0, 0, 0, 1);
    chk("R3 off holds", m_cnt[31:0], 32'd0);
    // R5 R8: restart mode, period 5, enable on
    cyc(1, 1, ctl(1, 1, 0, 5), 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, (i % 3) != 2);
    chk("R8 pending set", {31'd0, irq}, 32'd1);
    // R9: pending sticky, then cleared by write of 0
    repeat (3) cyc(0, 0, 0, 1);
    cyc(1, 1, ctl(0, 1, 0, 5), 0);
    chk("R9 cleared", {31'd0, irq}, 32'd0);
    // R4: upper bits ignored in compare
    cyc(1, 0, 32'h1000_0002, 0);
    cyc(1, 1, ctl(1, 0, 0, 4), 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    rd_sel = 1'b0; #1;
    chk("R4 upper ignored", rd_data, 32'd0);
    chk("R8 no pend when disabled", {31'd0, irq}, 32'd0);
    // R6: one-shot stops and holds; mode write resumes
    cyc(1, 0, 32'd0, 0);
    cyc(1, 1, ctl(2, 1, 0, 3), 0);
    repeat (8) cyc(0, 0, 0, 1);
    rd_sel = 1'b0; #1;
    chk("R6 held", rd_data, 32'd3);
    cyc(1, 1, ctl(2, 1, 1, 7), 0);
    repeat (6) cyc(0, 0, 0, 1);
    // R7: continuous wrap across 32 bits, event at low bits zero
    cyc(1, 0, 32'hFFFF_FFFD, 0);
    cyc(1, 1, ctl(3, 1, 0, 0), 0);
    repeat (5) cyc(0, 0, 0, 1);
    rd_sel = 1'b0; #1;
    chk("R7 wrapped", rd_data, 32'd2);
    // R4: already past the period, wraps low bits before the event
    cyc(1, 1, ctl(3, 1, 0, 1), 0);
    cyc(1, 0, 32'h0FFF_FFFE, 0);
    repeat (4) cyc(0, 0, 0, 1);
    // R10: write wins over tick in same cycle
    cyc(1, 0, 32'h0000_0040, 1);
    rd_sel = 1'b0; #1;
    chk("R10 write priority", rd_data, 32'h0000_0040);
    cyc(1, 1, ctl(1, 1, 0, 32'h41), 1);
    cyc(0, 0, 0, 1);
    rd_sel = 1'b0; #1;
    chk("R5 restart at 0x41", rd_data, 32'd0);
    repeat (5) cyc(0, 0, 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule